// File: doc/BRIEF.md
# Cache Control and Status Register

A 32-bit control and status word for a processor with split instruction and data caches. Software writes it over a small register bus (select, write enable, write data). The register image is presented on the read-data port at all times, and the select only qualifies writes. The word holds each cache's operating state, the freeze-on-interrupt options, the data-cache snoop enable and the diagnostic check-bit controls. The block drives these as outputs to the cache logic.

The block also takes in events from the cache side. An interrupt-taken pulse freezes any cache that is enabled and has freeze-on-interrupt set. Parity-error pulses from the four arrays (instruction tag, instruction data, data tag, data data) advance small saturating counters. A snoop-tag error pulse sets a sticky flag. Flush-done pulses end the flush-pending status that a flush command started.

Each flush command is a write-only bit. Writing it sends a one-cycle request pulse to the flush sequencer and raises a read-only pending bit.

Top module: `cachectl_csr`

## Requirements
- R1: After reset the read data is 0x000A0000, every output is 0, and both cache state fields are 00 (disabled).
- R2: A write sets the data cache state from write bits 3:2 and the instruction cache state from bits 1:0. Encoding: 11 = enabled, 01 = frozen, and a low bit of 0 = disabled. The new value shows on `dstate` and `istate` and in the read data in the cycle after the write.
- R3: A cycle with `irq_taken` high changes a cache state from 11 to 01 when that cache's freeze bit is set (bit 5 for data, bit 4 for instruction). The state does not change when the freeze bit is clear or the cache is not enabled.
- R4: When an interrupt freeze and a write to the state field fall in the same cycle, the freeze wins. A frozen cache stays frozen until a later write to its field.
- R5: Writing 1 to bit 22 (data) or bit 21 (instruction) produces a one-cycle `flush_req_d` or `flush_req_i` pulse in the next cycle. It also sets the pending bit (bit 14 for data, bit 15 for instruction). Bits 22 and 21 always read as 0.
- R6: A pending bit stays set until its flush-done pulse. A done pulse in the same cycle as a new flush command leaves the bit set.
- R7: Each parity-error pulse increments its 2-bit counter: instruction tag at 13:12, instruction data at 11:10, data tag at 9:8, data data at 7:6. A counter saturates at 3. A write of 00 to a counter's field clears it, and a write of any other value has no effect. An error pulse in the same cycle as a clearing write leaves the counter at 1.
- R8: A snoop-tag error pulse sets bit 30, which stays set until a write with bit 30 equal to 0. If the pulse and that write fall in the same cycle, the bit is set.
- R9: Bit 28 drives `diag_chk_sel`, bits 27:24 drive `diag_xor_bits`, and bit 23 drives `snoop_en`. All three are read/write.
- R10: Bits 20:19 always read 01 and bit 17 always reads 1. Bits 31, 29, 18 and 16 always read 0. Writes do not change the pending bits or bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register selected |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register image |
| irq_taken | input | 1 | Asynchronous interrupt taken, one-cycle pulse |
| flush_done_d | input | 1 | Data cache flush finished |
| flush_done_i | input | 1 | Instruction cache flush finished |
| err_itag | input | 1 | Instruction tag parity error pulse |
| err_idata | input | 1 | Instruction data parity error pulse |
| err_dtag | input | 1 | Data tag parity error pulse |
| err_ddata | input | 1 | Data data parity error pulse |
| err_snoop | input | 1 | Snoop tag parity error pulse |
| dstate | output | 2 | Data cache state |
| istate | output | 2 | Instruction cache state |
| flush_req_d | output | 1 | Data cache flush request pulse |
| flush_req_i | output | 1 | Instruction cache flush request pulse |
| snoop_en | output | 1 | Data cache snoop enable |
| diag_xor_bits | output | 4 | Test bits XORed into check bits on diagnostic write |
| diag_chk_sel | output | 1 | Diagnostic read returns check bits |

## Verification
Every result sits exactly one register stage from its cause: writes, freezes, counter steps, flag sets and pending changes. Each shows in the read data and outputs in the cycle after the edge that took the stimulus. The bench drives each stimulus for one cycle from the falling edge. It samples on the next falling edge, and checks the flush request pulse both there and one cycle later to prove it lasts one cycle. The same-cycle collisions of freeze with write, start with done, and clear with event each get their own single-cycle stimulus and are sampled after that one edge.

// File: rtl/cachectl_csr.sv
module cachectl_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        irq_taken,
  input  logic        flush_done_d,
  input  logic        flush_done_i,
  input  logic        err_itag,
  input  logic        err_idata,
  input  logic        err_dtag,
  input  logic        err_ddata,
  input  logic        err_snoop,
  output logic [1:0]  dstate,
  output logic [1:0]  istate,
  output logic        flush_req_d,
  output logic        flush_req_i,
  output logic        snoop_en,
  output logic [3:0]  diag_xor_bits,
  output logic        diag_chk_sel
);

  logic       wr;
  logic [1:0] dcs, ics;
  logic       frz_d, frz_i;
  logic       pend_d, pend_i;
  logic [1:0] cnt_it, cnt_id, cnt_dt, cnt_dd;
  logic       snp_err;
  logic       start_d, start_i;
  logic       unused_wbits;

  assign wr      = reg_sel & reg_we;
  assign start_d = wr & reg_wdata[22];
  assign start_i = wr & reg_wdata[21];
  assign unused_wbits = ^{reg_wdata[31], reg_wdata[29], reg_wdata[20:14]};

  function automatic logic [1:0] cnt_next(input logic [1:0] cur, input logic ev,
                                          input logic clr);
    logic [1:0] base;
    base = clr ? 2'd0 : cur;
    return (ev && base != 2'd3) ? base + 2'd1 : base;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcs <= 2'b00;
      ics <= 2'b00;
    end else begin
      if (irq_taken && frz_d && dcs == 2'b11) dcs <= 2'b01;
      else if (wr)                            dcs <= reg_wdata[3:2];
      if (irq_taken && frz_i && ics == 2'b11) ics <= 2'b01;
      else if (wr)                            ics <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_d         <= 1'b0;
      frz_i         <= 1'b0;
      snoop_en      <= 1'b0;
      diag_xor_bits <= 4'h0;
      diag_chk_sel  <= 1'b0;
    end else if (wr) begin
      frz_d         <= reg_wdata[5];
      frz_i         <= reg_wdata[4];
      snoop_en      <= reg_wdata[23];
      diag_xor_bits <= reg_wdata[27:24];
      diag_chk_sel  <= reg_wdata[28];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d      <= 1'b0;
      pend_i      <= 1'b0;
      flush_req_d <= 1'b0;
      flush_req_i <= 1'b0;
    end else begin
      pend_d      <= start_d | (pend_d & ~flush_done_d);
      pend_i      <= start_i | (pend_i & ~flush_done_i);
      flush_req_d <= start_d;
      flush_req_i <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_it  <= 2'd0;
      cnt_id  <= 2'd0;
      cnt_dt  <= 2'd0;
      cnt_dd  <= 2'd0;
      snp_err <= 1'b0;
    end else begin
      cnt_it  <= cnt_next(cnt_it, err_itag,  wr && reg_wdata[13:12] == 2'd0);
      cnt_id  <= cnt_next(cnt_id, err_idata, wr && reg_wdata[11:10] == 2'd0);
      cnt_dt  <= cnt_next(cnt_dt, err_dtag,  wr && reg_wdata[9:8]   == 2'd0);
      cnt_dd  <= cnt_next(cnt_dd, err_ddata, wr && reg_wdata[7:6]   == 2'd0);
      snp_err <= err_snoop | (snp_err & ~(wr & ~reg_wdata[30]));
    end
  end

  assign dstate = dcs;
  assign istate = ics;

  assign reg_rdata = {1'b0, snp_err, 1'b0, diag_chk_sel, diag_xor_bits, snoop_en,
                      2'b00, 2'b01, 1'b0, 1'b1, 1'b0, pend_i, pend_d,
                      cnt_it, cnt_id, cnt_dt, cnt_dd, frz_d, frz_i, dcs, ics};

endmodule

module cachectl_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        reg_we,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq_taken,
  input logic        flush_done_d,
  input logic [1:0]  dstate,
  input logic [1:0]  istate,
  input logic        flush_req_d
);
  logic wr;
  logic unused_chk;
  assign wr = reg_sel & reg_we;
  assign unused_chk = ^{reg_wdata[31:23], reg_wdata[21:14], reg_wdata[11:0]};

  // R3
  freeze_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && reg_rdata[5] && dstate == 2'b11) |=> dstate == 2'b01);

  // R3
  freeze_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && reg_rdata[4] && istate == 2'b11) |=> istate == 2'b01);

  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !irq_taken) |=> ($stable(dstate) && $stable(istate)));

  // R5
  flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata[22]) |=> (flush_req_d && reg_rdata[14]));

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[14] && flush_done_d && !(wr && reg_wdata[22])) |=> !reg_rdata[14]);

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[13:12] == 2'd3 && !(wr && reg_wdata[13:12] == 2'd0)) |=> reg_rdata[13:12] == 2'd3);
endmodule

bind cachectl_csr cachectl_csr_chk u_chk (.*);

// File: tb/cachectl_csr_bench.sv
`timescale 1ns/1ps
module cachectl_csr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_we = 0, irq_taken = 0, flush_done_d = 0, flush_done_i = 0;
  logic err_itag = 0, err_idata = 0, err_dtag = 0, err_ddata = 0, err_snoop = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] dstate, istate;
  logic flush_req_d, flush_req_i, snoop_en, diag_chk_sel;
  logic [3:0] diag_xor_bits;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cachectl_csr u_cachectl_csr (.*);

  localparam logic [31:0] VW [0:5] = '{32'h0000000F, 32'hFF9FFFFF, 32'h00000005,
                                       32'h0000000A, 32'h15000030, 32'h00000000};
  localparam logic [31:0] VR [0:5] = '{32'h000A000F, 32'h1F8A003F, 32'h000A0005,
                                       32'h000A000A, 32'h150A0030, 32'h000A0000};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // err = {snoop, itag, idata, dtag, ddata}
  task automatic cyc(input logic we, input logic [31:0] wd, input logic irq,
                     input logic fdd, input logic fdi, input logic [4:0] err);
    reg_sel = we; reg_we = we; reg_wdata = wd; irq_taken = irq;
    flush_done_d = fdd; flush_done_i = fdi;
    {err_snoop, err_itag, err_idata, err_dtag, err_ddata} = err;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 0; reg_we = 0; reg_wdata = 0; irq_taken = 0;
    flush_done_d = 0; flush_done_i = 0;
    {err_snoop, err_itag, err_idata, err_dtag, err_ddata} = 5'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'h000A0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after release", reg_rdata, 32'h000A0000);
    chk("R1 outputs", {24'd0, dstate, istate, flush_req_d, flush_req_i, snoop_en, diag_chk_sel},
        32'h0);
    chk("R1 diag bits", {28'd0, diag_xor_bits}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      cyc(1, VW[i], 0, 0, 0, 5'b0);
      chk("R2 R10 vector rdata", reg_rdata, VR[i]);
      chk("R2 state outputs", {28'd0, dstate, istate}, {28'd0, VR[i][3:0]});
      chk("R9 diag outputs", {26'd0, diag_chk_sel, diag_xor_bits, snoop_en},
          {26'd0, VR[i][28:23]});
    end

    cyc(1, 32'h3F, 0, 0, 0, 5'b0);
    cyc(0, 0, 1, 0, 0, 5'b0);
    chk("R3 freeze both", reg_rdata, 32'h000A0035);
    cyc(0, 0, 0, 0, 0, 5'b0);
    chk("R4 stays frozen", reg_rdata, 32'h000A0035);
    cyc(1, 32'h3F, 0, 0, 0, 5'b0);
    chk("R4 write re-enables", reg_rdata, 32'h000A003F);
    cyc(1, 32'h3F, 1, 0, 0, 5'b0);
    chk("R4 freeze beats write", reg_rdata, 32'h000A0035);
    cyc(1, 32'h0F, 0, 0, 0, 5'b0);
    cyc(0, 0, 1, 0, 0, 5'b0);
    chk("R3 no freeze when bit clear", reg_rdata, 32'h000A000F);
    cyc(1, 32'h31, 0, 0, 0, 5'b0);
    cyc(0, 0, 1, 0, 0, 5'b0);
    chk("R3 no freeze when not enabled", reg_rdata, 32'h000A0031);

    cyc(1, 32'h0, 0, 0, 0, 5'b0);
    cyc(1, 32'h00400000, 0, 0, 0, 5'b0);
    chk("R5 data flush pending", reg_rdata, 32'h000A4000);
    chk("R5 data flush req", {30'd0, flush_req_d, flush_req_i}, 32'h2);
    cyc(0, 0, 0, 0, 0, 5'b0);
    chk("R5 req one cycle", {30'd0, flush_req_d, flush_req_i}, 32'h0);
    chk("R6 pending held", reg_rdata, 32'h000A4000);
    cyc(0, 0, 0, 1, 0, 5'b0);
    chk("R6 done clears", reg_rdata, 32'h000A0000);
    cyc(1, 32'h00200000, 0, 0, 1, 5'b0);
    chk("R6 start with done stays pending", reg_rdata, 32'h000A8000);
    chk("R5 instr flush req", {30'd0, flush_req_d, flush_req_i}, 32'h1);
    cyc(0, 0, 0, 0, 1, 5'b0);
    chk("R6 instr done clears", reg_rdata, 32'h000A0000);

    cyc(0, 0, 0, 0, 0, 5'b01000);
    chk("R7 itag one", reg_rdata, 32'h000A1000);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 5'b01000);
    chk("R7 itag saturates", reg_rdata, 32'h000A3000);
    cyc(1, 32'h00003000, 0, 0, 0, 5'b0);
    chk("R7 nonzero write ignored", reg_rdata, 32'h000A3000);
    cyc(1, 32'h0, 0, 0, 0, 5'b01000);
    chk("R7 clear with event", reg_rdata, 32'h000A1000);
    cyc(1, 32'h0, 0, 0, 0, 5'b0);
    chk("R7 cleared", reg_rdata, 32'h000A0000);
    cyc(0, 0, 0, 0, 0, 5'b00111);
    chk("R7 other counters", reg_rdata, 32'h000A0540);

    cyc(0, 0, 0, 0, 0, 5'b10000);
    chk("R8 snoop flag set", reg_rdata, 32'h400A0540);
    cyc(1, 32'h40000540, 0, 0, 0, 5'b0);
    chk("R8 write one keeps flag", reg_rdata, 32'h400A0540);
    cyc(1, 32'h0, 0, 0, 0, 5'b10000);
    chk("R8 set wins over clear", reg_rdata, 32'h400A0000);
    cyc(1, 32'h0, 0, 0, 0, 5'b0);
    chk("R8 cleared", reg_rdata, 32'h000A0000);

    cyc(1, 32'hFFFFFFFF, 0, 0, 0, 5'b0);
    chk("R10 all-ones write", reg_rdata, 32'h1F8AC03F);
    cyc(0, 0, 0, 1, 1, 5'b0);
    chk("R10 pending cleared by done", reg_rdata, 32'h1F8A003F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule